// File: doc/BRIEF.md
# Converter Serial Configuration and Result Port

This block is the digital side of a multi-channel successive-approximation converter. It sits between a serial host and a stubbed conversion core. The host frames each exchange with a transfer-enable level and supplies a serial clock. While it does so, a 16-bit control word enters on the serial input, most significant bit first. In the same frame the most recent 12-bit conversion result leaves on the serial output. The control word selects the multiplexer channel, the power-saving behaviour and an option that appends the stored settings after the result.

The conversion core reports each finished result with a one-cycle strobe. The block latches the result and pulls the serial output low, so the host sees "conversion done" before it starts a frame. The result is sent as straight binary on the single-ended variant and as two's complement on the differential variant. The core delivers offset binary in both cases. After the last serial clock pulse of a frame the output driver is released. A small power-state tracker follows the selected mode across conversions and times the recovery after an acquisition request wakes the device.

All serial inputs are sampled on the system clock, which must run several times faster than the serial clock.

Top module: `adc_sif`

## Requirements
- R1: After reset the channel is 0, the power mode is 01 (fully powered), readback is off, the output driver is off (`sdo_oe`=0), `pwr_ready`=1 and `pwr_low`=0.
- R2: A frame delivers a 16-bit word on `sdi`, sampled at rising `sclk` edges, first bit = bit 15. At the 16th rising edge the word is loaded when bits 15:14 are 11: channel from bits 13:11, power mode from bits 10:9, readback enable from bit 7.
- R3: A word whose bits 15:14 are not 11 leaves the channel, power mode and readback enable unchanged.
- R4: On the differential variant (`DIFF`=1) bit 13 is ignored, and the channel is bits 12:11 with `chan_sel[2]`=0.
- R5: One cycle after `conv_done` while no frame is active, `sdo_oe`=1 and `sdo`=0. This holds until a frame starts.
- R6: When `xfer_en` rises, `sdo` presents the result MSB. Each falling `sclk` edge advances one bit, 12 result bits MSB first. The single-ended variant sends the core code unchanged. The differential variant sends the core code with its MSB inverted (two's complement).
- R7: If readback is enabled at frame start, the 9 bits after the result are, in order: 1, 1, channel (3 bits, MSB first), power mode (2 bits), 0, readback enable. They show the settings held at frame start.
- R8: A frame is 16 pulses when readback is off (bits 13..16 sent as 0) and 21 pulses when it is on. The falling edge of the last pulse clears `sdo_oe`.
- R9: A `conv_done` while powered with mode 00 or 1x sets `pwr_low`=1 and `pwr_ready`=0. With mode 01, `pwr_ready` stays 1.
- R10: `acq_start` during low power starts a recovery. `pwr_ready` returns exactly `PD_CYC` cycles after the sampling edge if mode 00 was entered, or `SL_CYC` cycles if 1x was entered. It is 0 one cycle earlier.
- R11: Word bits 8 and 6:0 are not stored; they read back as 0 in the readback field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial control word input |
| xfer_en | input | 1 | High for the duration of a frame |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_data | input | RES_W | Offset-binary result from the core |
| acq_start | input | 1 | Acquisition request, wakes from low power |
| sdo | output | 1 | Serial output data value |
| sdo_oe | output | 1 | Serial output driver enable (0 = high impedance) |
| chan_sel | output | 3 | Selected multiplexer channel |
| pwr_mode | output | 2 | Stored power mode field |
| pwr_ready | output | 1 | Converter fully powered |
| pwr_low | output | 1 | Converter in power-down or sleep |

## Verification
A serial clock edge is seen one system cycle after it arrives at the port. Its effect on `sdo`, `sdo_oe` and the stored settings lands at the following edge. The bench therefore holds each `sclk` level for three system cycles and samples one time unit after a system edge, so every result is settled. The completion indicator is checked one cycle after the strobe. Recovery timing is checked exactly: `pwr_ready` must be low N-1 edges after the sampling edge of `acq_start` and high at edge N, for both recovery lengths.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  localparam int CFG_W  = 16;
  localparam int RB_W   = 9;
  localparam int CH_W   = 3;
  localparam int MODE_W = 2;
  localparam logic [1:0] LOAD_KEY  = 2'b11;
  localparam logic [1:0] MODE_FULL = 2'b01;
  localparam logic [1:0] MODE_DOWN = 2'b00;

  typedef enum logic [1:0] {PW_ON, PW_LOW, PW_WAKE} pw_state_t;

  // readback field: key, channel, mode, zero, readback enable
  function automatic logic [RB_W-1:0] rb_word(logic [CH_W-1:0] ch,
                                              logic [MODE_W-1:0] md,
                                              logic rb);
    return {LOAD_KEY, ch, md, 1'b0, rb};
  endfunction
endpackage

// File: rtl/adc_sif_cfg.sv
module adc_sif_cfg
  import adc_sif_pkg::*;
#(
  parameter bit DIFF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_en,
  input  logic              bit_rise,
  input  logic              sdi,
  output logic [CH_W-1:0]   chan,
  output logic [MODE_W-1:0] mode,
  output logic              rb_en
);
  localparam int CNT_W  = $clog2(CFG_W + 1);
  localparam int CH_LO  = CFG_W - 5;
  localparam int MD_LO  = CFG_W - 7;
  localparam int RB_POS = CFG_W - 9;

  logic [CFG_W-2:0]  sr;
  logic [CNT_W-1:0]  rcnt;
  logic [CFG_W-1:0]  word;
  logic              take, load_try, key_ok;
  logic [CH_W-1:0]   ch_next;

  assign word     = {sr, sdi};
  assign take     = bit_rise && xfer_en && (rcnt < CNT_W'(CFG_W));
  assign load_try = take && (rcnt == CNT_W'(CFG_W - 1));
  assign key_ok   = (word[CFG_W-1:CFG_W-2] == LOAD_KEY);

  generate
    if (DIFF) begin : g_diff
      assign ch_next = {1'b0, word[CH_LO+1:CH_LO]};
    end else begin : g_se
      assign ch_next = word[CH_LO+2:CH_LO];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      rcnt  <= '0;
      chan  <= '0;
      mode  <= MODE_FULL;
      rb_en <= 1'b0;
    end else if (xfer_start) begin
      rcnt <= '0;
    end else if (take) begin
      sr   <= word[CFG_W-2:0];
      rcnt <= rcnt + 1'b1;
      if (load_try && key_ok) begin
        chan  <= ch_next;
        mode  <= word[MD_LO+1:MD_LO];
        rb_en <= word[RB_POS];
      end
    end
  end

  // R3: a word without the load key keeps every setting
  a_r3_no_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_try && !key_ok) |=> ($stable(chan) && $stable(mode) && $stable(rb_en)));

  // R4: differential variant never selects an upper channel
  a_r4_diff_chan: assert property (@(posedge clk) disable iff (!rst_n)
    DIFF |-> !chan[CH_W-1]);
endmodule

// File: rtl/adc_sif_sdo.sv
module adc_sif_sdo
  import adc_sif_pkg::*;
#(
  parameter int RES_W = 12,
  parameter bit DIFF  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_en,
  input  logic             bit_fall,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rb_en,
  input  logic [RB_W-1:0]  rb_bits,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             tx_last
);
  localparam int SH_W     = RES_W + RB_W;
  localparam int FL_W     = $clog2(SH_W + 1);
  localparam int FR_SHORT = CFG_W;
  localparam int FR_LONG  = SH_W;

  // offset binary from the core -> output coding of this variant
  function automatic logic [RES_W-1:0] code_fmt(logic [RES_W-1:0] c);
    return DIFF ? {~c[RES_W-1], c[RES_W-2:0]} : c;
  endfunction

  logic [RES_W-1:0] res_q;
  logic [SH_W-1:0]  sh;
  logic [FL_W-1:0]  tcnt, flen;
  logic             active, oe;

  assign tx_last = bit_fall && active && (tcnt == flen - FL_W'(1));
  assign sdo     = active ? sh[SH_W-1] : 1'b0;
  assign sdo_oe  = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      sh     <= '0;
      tcnt   <= '0;
      flen   <= FL_W'(FR_SHORT);
      active <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (conv_done) res_q <= conv_data;
      if (xfer_start) begin
        sh     <= {code_fmt(res_q), rb_en ? rb_bits : {RB_W{1'b0}}};
        flen   <= rb_en ? FL_W'(FR_LONG) : FL_W'(FR_SHORT);
        tcnt   <= '0;
        active <= 1'b1;
        oe     <= 1'b1;
      end else if (active && !xfer_en) begin
        active <= 1'b0;
        oe     <= 1'b0;
      end else if (tx_last) begin
        active <= 1'b0;
        oe     <= 1'b0;
      end else if (active && bit_fall) begin
        sh   <= sh << 1;
        tcnt <= tcnt + 1'b1;
      end else if (!active && conv_done) begin
        oe <= 1'b1;
      end
    end
  end

  // R5: completion shows as a driven low level
  a_r5_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !active && !xfer_start) |=> (sdo_oe && !sdo));

  // R8: last pulse of a frame releases the output
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !sdo_oe);
endmodule

// File: rtl/adc_sif_pwr.sv
module adc_sif_pwr
  import adc_sif_pkg::*;
#(
  parameter int PD_CYC = 30000,
  parameter int SL_CYC = 420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              acq_start,
  input  logic [MODE_W-1:0] mode,
  output logic              ready,
  output logic              low
);
  localparam int MAXC  = (PD_CYC > SL_CYC) ? PD_CYC : SL_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  pw_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             deep;

  assign ready = (state == PW_ON);
  assign low   = (state == PW_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PW_ON;
      cnt   <= '0;
      deep  <= 1'b0;
    end else begin
      unique case (state)
        PW_ON: if (conv_done && mode != MODE_FULL) begin
          state <= PW_LOW;
          deep  <= (mode == MODE_DOWN);
        end
        PW_LOW: if (acq_start) begin
          state <= PW_WAKE;
          cnt   <= deep ? CNT_W'(PD_CYC - 1) : CNT_W'(SL_CYC - 1);
        end
        PW_WAKE: if (cnt == '0) state <= PW_ON;
                 else cnt <= cnt - 1'b1;
        default: state <= PW_ON;
      endcase
    end
  end

  // R9: a low-power mode takes effect at the end of a conversion
  a_r9_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && conv_done && mode != MODE_FULL) |=> (low && !ready));

  // R10: waking is never immediate
  a_r10_wake_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (low && acq_start) |=> !ready);
endmodule

// File: rtl/adc_sif.sv
module adc_sif
  import adc_sif_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter bit DIFF   = 1'b0,
  parameter int PD_CYC = 30000,
  parameter int SL_CYC = 420
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             xfer_en,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             acq_start,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [2:0]       chan_sel,
  output logic [1:0]       pwr_mode,
  output logic             pwr_ready,
  output logic             pwr_low
);
  logic sclk_d, xfer_d;
  logic bit_rise, bit_fall, xfer_start, tx_last;
  logic [CH_W-1:0]   chan;
  logic [MODE_W-1:0] mode;
  logic              rb_en;
  logic [RB_W-1:0]   rb_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      xfer_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      xfer_d <= xfer_en;
    end
  end

  assign bit_rise   = sclk && !sclk_d;
  assign bit_fall   = !sclk && sclk_d;
  assign xfer_start = xfer_en && !xfer_d;
  assign rb_bits    = rb_word(chan, mode, rb_en);

  adc_sif_cfg #(.DIFF(DIFF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_en(xfer_en),
    .bit_rise(bit_rise), .sdi(sdi), .chan(chan), .mode(mode), .rb_en(rb_en)
  );

  adc_sif_sdo #(.RES_W(RES_W), .DIFF(DIFF)) u_sdo (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_en(xfer_en),
    .bit_fall(bit_fall), .conv_done(conv_done), .conv_data(conv_data),
    .rb_en(rb_en), .rb_bits(rb_bits), .sdo(sdo), .sdo_oe(sdo_oe),
    .tx_last(tx_last)
  );

  adc_sif_pwr #(.PD_CYC(PD_CYC), .SL_CYC(SL_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .acq_start(acq_start),
    .mode(mode), .ready(pwr_ready), .low(pwr_low)
  );

  assign chan_sel = chan;
  assign pwr_mode = mode;

  // R2: a loaded word is never accepted outside a frame
  a_r2_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> ($stable(chan_sel) && $stable(pwr_mode)));
endmodule

// File: tb/adc_sif_test.sv
module adc_sif_test;
  localparam int PD = 40;
  localparam int SL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, xfer_en = 1'b0, conv_done = 1'b0, acq_start = 1'b0;
  logic [11:0] conv_data = '0;
  logic sdo_s, oe_s, rdy_s, low_s, sdo_d, oe_d, rdy_d, low_d;
  logic [2:0] ch_s, ch_d;
  logic [1:0] md_s, md_d;
  logic [20:0] cap_s, cap_d;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_sif #(.RES_W(12), .DIFF(1'b0), .PD_CYC(PD), .SL_CYC(SL)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .xfer_en(xfer_en),
    .conv_done(conv_done), .conv_data(conv_data), .acq_start(acq_start),
    .sdo(sdo_s), .sdo_oe(oe_s), .chan_sel(ch_s), .pwr_mode(md_s),
    .pwr_ready(rdy_s), .pwr_low(low_s));

  adc_sif #(.RES_W(12), .DIFF(1'b1), .PD_CYC(PD), .SL_CYC(SL)) uut_diff (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .xfer_en(xfer_en),
    .conv_done(conv_done), .conv_data(conv_data), .acq_start(acq_start),
    .sdo(sdo_d), .sdo_oe(oe_d), .chan_sel(ch_d), .pwr_mode(md_d),
    .pwr_ready(rdy_d), .pwr_low(low_d));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic convert(input logic [11:0] c);
    conv_data = c; conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
    tick(1);
  endtask

  task automatic run_frame(input logic [15:0] w, input int n);
    xfer_en = 1'b1;
    tick(3);
    for (int i = 0; i < n; i++) begin
      sdi  = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b1;
      tick(3);
      cap_s[20-i] = sdo_s;
      cap_d[20-i] = sdo_d;
      sclk = 1'b0;
      tick(3);
    end
    check("R8 release se", {31'd0, oe_s}, 32'd0);
    check("R8 release diff", {31'd0, oe_d}, 32'd0);
    xfer_en = 1'b0;
    tick(2);
  endtask

  task automatic wake(input int n);
    acq_start = 1'b1;
    @(posedge clk); #1;
    acq_start = 1'b0;
    tick(n - 1);
    check("R10 still waking", {30'd0, rdy_s, rdy_d}, 32'd0);
    tick(1);
    check("R10 ready on time", {30'd0, rdy_s, rdy_d}, 32'd3);
  endtask

  function automatic logic [11:0] pick_code(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'((k * 1187 + 91) % 4096);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] prev_ch;
    logic [11:0] c;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 chan", {26'd0, ch_s, ch_d}, 32'd0);
    check("R1 mode", {28'd0, md_s, md_d}, 32'h5);
    check("R1 oe", {30'd0, oe_s, oe_d}, 32'd0);
    check("R1 pwr", {28'd0, rdy_s, rdy_d, low_s, low_d}, 32'hC);

    // R5 completion indicator
    convert(12'h9C3);
    check("R5 done se", {30'd0, oe_s, sdo_s}, 32'h2);
    check("R5 done diff", {30'd0, oe_d, sdo_d}, 32'h2);

    // R2/R4/R6/R8: keyed load, ch5, mode 01, readback on, junk bits 8 and 6:0
    run_frame(16'hEAFF, 16);
    check("R6 se code", {20'd0, cap_s[20:9]}, {20'd0, 12'h9C3});
    check("R6 diff code", {20'd0, cap_d[20:9]}, {20'd0, 12'h1C3});
    check("R8 short tail", {24'd0, cap_s[8:5], cap_d[8:5]}, 32'd0);
    check("R2 chan se", {29'd0, ch_s}, 32'd5);
    check("R4 chan diff", {29'd0, ch_d}, 32'd1);
    check("R2 mode", {28'd0, md_s, md_d}, 32'h5);

    // R3: key 01 ignored; R7/R11 readback of current settings
    convert(12'h3E0);
    run_frame(16'h5000, 21);
    check("R6 se code 2", {20'd0, cap_s[20:9]}, {20'd0, 12'h3E0});
    check("R7 R11 readback se", {23'd0, cap_s[8:0]}, {23'd0, 2'b11, 3'd5, 2'b01, 1'b0, 1'b1});
    check("R7 R11 readback diff", {23'd0, cap_d[8:0]}, {23'd0, 2'b11, 3'd1, 2'b01, 1'b0, 1'b1});
    check("R3 unchanged", {24'd0, ch_s, ch_d[1:0], md_s, md_d}, {24'd0, 3'd5, 2'd1, 2'b01, 2'b01});

    // sweep of codes and channels, readback shows settings at frame start
    prev_ch = 3'd5;
    for (int k = 0; k < 8; k++) begin
      c = pick_code(k);
      convert(c);
      run_frame(16'hC000 | 16'(k << 11) | 16'h0200 | 16'h0080, 21);
      check("R6 sweep se", {20'd0, cap_s[20:9]}, {20'd0, c});
      check("R6 sweep diff", {20'd0, cap_d[20:9]}, {20'd0, c ^ 12'h800});
      check("R7 sweep rb se", {23'd0, cap_s[8:0]}, {23'd0, 2'b11, prev_ch, 2'b01, 1'b0, 1'b1});
      check("R7 sweep rb diff", {23'd0, cap_d[8:0]}, {23'd0, 2'b11, 1'b0, prev_ch[1:0], 2'b01, 1'b0, 1'b1});
      check("R2 sweep chan", {26'd0, ch_s, ch_d}, {26'd0, 3'(k), 1'b0, 2'(k)});
      prev_ch = 3'(k);
    end

    // R9/R10 power down
    run_frame(16'hD800, 21);
    check("R2 mode 00", {28'd0, md_s, md_d}, 32'd0);
    convert(12'h123);
    check("R9 low", {28'd0, rdy_s, rdy_d, low_s, low_d}, 32'h3);
    wake(PD);

    // R9/R10 sleep
    run_frame(16'hC400, 16);
    convert(12'h456);
    check("R9 sleep", {28'd0, rdy_s, rdy_d, low_s, low_d}, 32'h3);
    wake(SL);

    // R9 fully powered mode stays ready
    run_frame(16'hC200, 16);
    convert(12'h789);
    check("R9 full", {28'd0, rdy_s, rdy_d, low_s, low_d}, 32'hC);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule